// File: doc/BRIEF.md
# NAND Host Mode and Bus Bridge

This block connects a 16-bit register-style host bus to an 8-bit raw NAND flash device. The host programs a one-byte mode register that sets the whole bus phase at once: chip enable, the command and address latch lines, write-protect release, and the power and LED controls. A separate byte register reports the device ready/busy line.

Accesses to the data register turn into NAND byte cycles, using whatever latch phase the mode register currently holds. A narrow access makes one byte cycle. A wide access makes two byte cycles, low byte first. The host request is held, and the bridge returns a one-cycle acknowledge only after every byte cycle of that access is complete.

Write strobes and read strobes are timed by parameters. Each strobe is followed by a recovery window before the next cycle may begin.

Top module: `nand_host_bridge`

## Requirements
- R1: After reset the mode register is 0x00. Chip enable is deasserted (nf_ce_n = 1), both strobes are high, nf_doe is 0, the power and LED outputs are 0, and hst_ack is 0.
- R2: The mode register is at offset 4 and reads back the byte written. Its bits drive the device pins as follows: bit 0 drives nf_cle, bit 1 drives nf_ale, bit 4 asserts chip enable (nf_ce_n = !bit4), bit 7 drives nf_wp_n, and bit 2 drives led_en. Bits 6:5 are stored and read back only.
- R3: Mode 0x00 is standby: chip enable is off and both latch lines are low. pwr_en is high only when bits 3 and 2 are both set, so 0x0C turns power on and 0x08 turns it off.
- R4: The status register is at offset 5. Bit 7 reads 1 while nf_rb_n is low (busy), after SYNC_STAGES clocks of synchronisation. All other status bits read 0.
- R5: A narrow write to the data register at offset 0 makes exactly one write strobe carrying hst_wdata[7:0]. The latch lines follow the mode register: 0x95 gives command cycles (nf_cle = 1), 0x96 gives address cycles (nf_ale = 1), and 0x94 gives data cycles (both 0).
- R6: A wide data write makes two write strobes: hst_wdata[7:0] first, then hst_wdata[15:8].
- R7: A wide data read makes two read strobes. The first byte read returns in hst_rdata[7:0] and the second in hst_rdata[15:8].
- R8: A narrow data read makes one read strobe and returns the byte in hst_rdata[7:0], with hst_rdata[15:8] = 0.
- R9: Each write strobe is low for exactly STROBE_CYC clocks. While it is low and across its rising edge, nf_doe = 1 and nf_dout is stable. Each read strobe is low for exactly STROBE_CYC clocks, and nf_doe = 0 during it.
- R10: hst_ack is a single-cycle pulse. It arrives 1 + n*(STROBE_CYC+HOLD_CYC) clocks after the request is taken, where n is the number of byte cycles (0 for the mode and status registers). The write and read strobes are never low together, and no strobe occurs without a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_req | input | 1 | Host request, held until hst_ack |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| hst_addr | input | ADDR_W | Register offset |
| hst_wdata | input | 16 | Host write data |
| hst_ack | output | 1 | One-cycle completion pulse |
| hst_rdata | output | 16 | Read data, valid with hst_ack |
| nf_ce_n | output | 1 | Device chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_wp_n | output | 1 | Write-protect release |
| nf_dout | output | 8 | Byte driven to the device |
| nf_doe | output | 1 | Output enable for nf_dout |
| nf_din | input | 8 | Byte returned by the device |
| nf_rb_n | input | 1 | Device ready (1) / busy (0) |
| pwr_en | output | 1 | Card power enable |
| led_en | output | 1 | Activity LED enable |

## Verification
A corrupted mode byte shows on the pins during the very next cycle after the write, and the full-range mode sweep catches it at that point. A wrong byte-cycle counter or sequencer state changes either the acknowledge latency or the number of strobes logged by the device model, so the error is caught within one access. Byte-order or capture-timing faults return read data that differs from the arithmetic pattern the model drives, and this is seen on the first wide read.

// File: rtl/nhb_pkg.sv
package nhb_pkg;

   // Layout of the mode byte: bit positions are decoded by the pin logic
   typedef struct packed {
      logic       wp_rel;   // bit 7
      logic [1:0] ecc_sel;  // bits 6:5, stored only
      logic       ce;       // bit 4
      logic       pwr;      // bit 3
      logic       led;      // bit 2
      logic       ale;      // bit 1
      logic       cle;      // bit 0
   } mode_t;

   typedef enum logic [1:0] {
      CYC_IDLE,
      CYC_STROBE,
      CYC_RECOV
   } cyc_st_e;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_LO,
      SEQ_HI
   } seq_st_e;

endpackage

// File: rtl/nhb_mode_regs.sv
module nhb_mode_regs
   import nhb_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_wr,
   input  logic [7:0] mode_wdata,
   input  logic       nf_rb_n,
   output mode_t      mode,
   output logic       busy
);

   mode_t mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (mode_wr) mode_q <= mode_t'(mode_wdata);
   end

   assign mode = mode_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign busy = ~nf_rb_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2+1-1:0], ~nf_rb_n} >> 0;
         end
         assign busy = sync_q[SYNC_STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/nhb_byte_cycle.sv
module nhb_byte_cycle
   import nhb_pkg::*;
#(
   parameter int STROBE_CYC = 2,
   parameter int HOLD_CYC   = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       rd,
   input  logic [7:0] wbyte,
   input  logic [7:0] nf_din,
   output logic       nf_we_n,
   output logic       nf_re_n,
   output logic [7:0] nf_dout,
   output logic       nf_doe,
   output logic [7:0] rbyte,
   output logic       done
);

   localparam int MAXC = (STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC;
   localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
   localparam logic [CW-1:0] STR_LAST = CW'(STROBE_CYC - 1);
   localparam logic [CW-1:0] HLD_LAST = CW'(HOLD_CYC - 1);

   cyc_st_e       st_q;
   logic [CW-1:0] cnt_q;
   logic          rd_q;
   logic [7:0]    dout_q;
   logic [7:0]    rbyte_q;
   logic          last_str;
   logic          last_hld;

   assign last_str = (st_q == CYC_STROBE) && (cnt_q == STR_LAST);
   assign last_hld = (st_q == CYC_RECOV)  && (cnt_q == HLD_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= CYC_IDLE;
         cnt_q   <= '0;
         rd_q    <= 1'b0;
         dout_q  <= '0;
         rbyte_q <= '0;
      end else begin
         unique case (st_q)
            CYC_IDLE: begin
               if (start) begin
                  st_q   <= CYC_STROBE;
                  cnt_q  <= '0;
                  rd_q   <= rd;
                  dout_q <= wbyte;
               end
            end
            CYC_STROBE: begin
               if (last_str) begin
                  st_q  <= CYC_RECOV;
                  cnt_q <= '0;
                  if (rd_q) rbyte_q <= nf_din;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            CYC_RECOV: begin
               if (last_hld) begin
                  cnt_q <= '0;
                  if (start) begin
                     st_q   <= CYC_STROBE;
                     rd_q   <= rd;
                     dout_q <= wbyte;
                  end else begin
                     st_q <= CYC_IDLE;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: st_q <= CYC_IDLE;
         endcase
      end
   end

   assign nf_we_n = !((st_q == CYC_STROBE) && !rd_q);
   assign nf_re_n = !((st_q == CYC_STROBE) &&  rd_q);
   assign nf_doe  = (st_q != CYC_IDLE) && !rd_q;
   assign nf_dout = dout_q;
   assign rbyte   = rbyte_q;
   assign done    = last_hld;

endmodule

// File: rtl/nhb_word_seq.sv
module nhb_word_seq
   import nhb_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int DATA_OFS = 0,
   parameter int MODE_OFS = 4,
   parameter int STAT_OFS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_req,
   input  logic              hst_we,
   input  logic              hst_wide,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic [15:0]       hst_wdata,
   output logic              hst_ack,
   output logic [15:0]       hst_rdata,
   input  mode_t             mode,
   input  logic              busy,
   output logic              mode_wr,
   output logic              cyc_start,
   output logic              cyc_rd,
   output logic [7:0]        cyc_wbyte,
   input  logic              cyc_done,
   input  logic [7:0]        cyc_rbyte
);

   seq_st_e     st_q;
   logic        ack_q;
   logic [15:0] rdata_q;
   logic        wide_q;
   logic        rd_q;
   logic [7:0]  hi_q;
   logic [7:0]  lo_q;
   logic        accept;
   logic        is_data;
   logic [15:0] reg_val;

   assign accept  = hst_req && !ack_q && (st_q == SEQ_IDLE);
   assign is_data = (hst_addr == ADDR_W'(DATA_OFS));
   assign mode_wr = accept && hst_we && (hst_addr == ADDR_W'(MODE_OFS));

   always_comb begin
      reg_val = '0;
      if (hst_addr == ADDR_W'(MODE_OFS))      reg_val = {8'h00, mode};
      else if (hst_addr == ADDR_W'(STAT_OFS)) reg_val = {8'h00, busy, 7'b0};
   end

   assign cyc_start = (accept && is_data) || ((st_q == SEQ_LO) && cyc_done && wide_q);
   assign cyc_rd    = accept ? !hst_we : rd_q;
   assign cyc_wbyte = accept ? hst_wdata[7:0] : hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SEQ_IDLE;
         ack_q   <= 1'b0;
         rdata_q <= '0;
         wide_q  <= 1'b0;
         rd_q    <= 1'b0;
         hi_q    <= '0;
         lo_q    <= '0;
      end else begin
         ack_q <= 1'b0;
         unique case (st_q)
            SEQ_IDLE: begin
               if (accept) begin
                  wide_q <= hst_wide;
                  rd_q   <= !hst_we;
                  hi_q   <= hst_wdata[15:8];
                  if (is_data) begin
                     st_q <= SEQ_LO;
                  end else begin
                     ack_q <= 1'b1;
                     if (!hst_we) rdata_q <= reg_val;
                  end
               end
            end
            SEQ_LO: begin
               if (cyc_done) begin
                  if (wide_q) begin
                     lo_q <= cyc_rbyte;
                     st_q <= SEQ_HI;
                  end else begin
                     ack_q <= 1'b1;
                     st_q  <= SEQ_IDLE;
                     if (rd_q) rdata_q <= {8'h00, cyc_rbyte};
                  end
               end
            end
            SEQ_HI: begin
               if (cyc_done) begin
                  ack_q <= 1'b1;
                  st_q  <= SEQ_IDLE;
                  if (rd_q) rdata_q <= {cyc_rbyte, lo_q};
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign hst_ack   = ack_q;
   assign hst_rdata = rdata_q;

endmodule

// File: rtl/nand_host_bridge.sv
module nand_host_bridge
   import nhb_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_OFS    = 0,
   parameter int MODE_OFS    = 4,
   parameter int STAT_OFS    = 5,
   parameter int STROBE_CYC  = 2,
   parameter int HOLD_CYC    = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_req,
   input  logic              hst_we,
   input  logic              hst_wide,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic [15:0]       hst_wdata,
   output logic              hst_ack,
   output logic [15:0]       hst_rdata,
   output logic              nf_ce_n,
   output logic              nf_cle,
   output logic              nf_ale,
   output logic              nf_we_n,
   output logic              nf_re_n,
   output logic              nf_wp_n,
   output logic [7:0]        nf_dout,
   output logic              nf_doe,
   input  logic [7:0]        nf_din,
   input  logic              nf_rb_n,
   output logic              pwr_en,
   output logic              led_en
);

   generate
      if (STROBE_CYC < 2) begin : g_bad_strobe
         $error("STROBE_CYC must be at least 2");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("HOLD_CYC must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES == 1) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
      if ((1 << ADDR_W) <= MODE_OFS || (1 << ADDR_W) <= STAT_OFS) begin : g_bad_addr
         $error("ADDR_W too narrow for register offsets");
      end
   endgenerate

   mode_t      mode;
   logic       busy;
   logic       mode_wr;
   logic       cyc_start;
   logic       cyc_rd;
   logic [7:0] cyc_wbyte;
   logic       cyc_done;
   logic [7:0] cyc_rbyte;

   nhb_mode_regs #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_wr    (mode_wr),
      .mode_wdata (hst_wdata[7:0]),
      .nf_rb_n    (nf_rb_n),
      .mode       (mode),
      .busy       (busy)
   );

   nhb_word_seq #(
      .ADDR_W   (ADDR_W),
      .DATA_OFS (DATA_OFS),
      .MODE_OFS (MODE_OFS),
      .STAT_OFS (STAT_OFS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .hst_req   (hst_req),
      .hst_we    (hst_we),
      .hst_wide  (hst_wide),
      .hst_addr  (hst_addr),
      .hst_wdata (hst_wdata),
      .hst_ack   (hst_ack),
      .hst_rdata (hst_rdata),
      .mode      (mode),
      .busy      (busy),
      .mode_wr   (mode_wr),
      .cyc_start (cyc_start),
      .cyc_rd    (cyc_rd),
      .cyc_wbyte (cyc_wbyte),
      .cyc_done  (cyc_done),
      .cyc_rbyte (cyc_rbyte)
   );

   nhb_byte_cycle #(
      .STROBE_CYC (STROBE_CYC),
      .HOLD_CYC   (HOLD_CYC)
   ) u_cyc (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (cyc_start),
      .rd      (cyc_rd),
      .wbyte   (cyc_wbyte),
      .nf_din  (nf_din),
      .nf_we_n (nf_we_n),
      .nf_re_n (nf_re_n),
      .nf_dout (nf_dout),
      .nf_doe  (nf_doe),
      .rbyte   (cyc_rbyte),
      .done    (cyc_done)
   );

   assign nf_cle  = mode.cle;
   assign nf_ale  = mode.ale;
   assign nf_ce_n = !mode.ce;
   assign nf_wp_n = mode.wp_rel;
   assign pwr_en  = mode.pwr && mode.led;
   assign led_en  = mode.led;

endmodule

// File: rtl/nhb_host_bridge_chk.sv
module nhb_host_bridge_chk #(
   parameter int STROBE_CYC = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       hst_req,
   input logic       hst_ack,
   input logic       nf_we_n,
   input logic       nf_re_n,
   input logic [7:0] nf_dout,
   input logic       nf_doe
);

   int unsigned we_low_q;
   int unsigned re_low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_low_q <= 0;
         re_low_q <= 0;
      end else begin
         we_low_q <= nf_we_n ? 0 : we_low_q + 1;
         re_low_q <= nf_re_n ? 0 : re_low_q + 1;
      end
   end

   // R10
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nf_we_n && !nf_re_n));

   // R10
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hst_ack |=> !hst_ack);

   // R10
   strobe_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!nf_we_n || !nf_re_n) |-> hst_req);

   // R9
   we_rise_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!nf_we_n) |=> (nf_we_n ? ($stable(nf_dout) && nf_doe) : 1'b1));

   // R9
   we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nf_we_n && we_low_q != 0) |-> (we_low_q == STROBE_CYC));

   // R9
   re_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nf_re_n && re_low_q != 0) |-> (re_low_q == STROBE_CYC));

   // R9
   read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nf_re_n |-> !nf_doe);

endmodule

bind nand_host_bridge nhb_host_bridge_chk #(
   .STROBE_CYC (STROBE_CYC)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .hst_req (hst_req),
   .hst_ack (hst_ack),
   .nf_we_n (nf_we_n),
   .nf_re_n (nf_re_n),
   .nf_dout (nf_dout),
   .nf_doe  (nf_doe)
);

// File: tb/test_nand_host_bridge.sv
`timescale 1ns/1ps
module test_nand_host_bridge;

   localparam int S = 2;
   localparam int H = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_req = 1'b0, hst_we = 1'b0, hst_wide = 1'b0;
   logic [2:0]  hst_addr = '0;
   logic [15:0] hst_wdata = '0;
   logic        hst_ack;
   logic [15:0] hst_rdata;
   logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_wp_n, nf_doe;
   logic [7:0]  nf_dout, nf_din;
   logic        nf_rb_n = 1'b1;
   logic        pwr_en, led_en;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   nand_host_bridge #(.STROBE_CYC(S), .HOLD_CYC(H)) i_nand_host_bridge (
      .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we),
      .hst_wide(hst_wide), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
      .hst_ack(hst_ack), .hst_rdata(hst_rdata), .nf_ce_n(nf_ce_n),
      .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
      .nf_wp_n(nf_wp_n), .nf_dout(nf_dout), .nf_doe(nf_doe), .nf_din(nf_din),
      .nf_rb_n(nf_rb_n), .pwr_en(pwr_en), .led_en(led_en));

   // ---------------- device model ----------------
   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37 + 5) & 255);
   endfunction

   logic [7:0] lg_b [0:63];
   logic       lg_c [0:63];
   logic       lg_a [0:63];
   int         lg_w [0:63];
   int         lg_n = 0;
   int         wlow = 0;
   int         rlow = 0;
   int         rd_idx = 0;
   int         rd_w = 0;
   int         rd_n = 0;

   assign nf_din = pat(rd_idx);

   always @(negedge clk) begin
      if (!nf_we_n) wlow++;
      if (!nf_re_n) rlow++;
   end

   always @(posedge nf_we_n) begin
      if (rst_n && lg_n < 64) begin
         lg_b[lg_n] = nf_dout;
         lg_c[lg_n] = nf_cle;
         lg_a[lg_n] = nf_ale;
         lg_w[lg_n] = wlow;
         lg_n++;
      end
      wlow = 0;
   end

   always @(posedge nf_re_n) begin
      if (rst_n) begin
         rd_w = rlow;
         rd_idx++;
         rd_n++;
      end
      rlow = 0;
   end

   // ---------------- helpers ----------------
   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   task automatic hacc(input logic we, input logic wide, input logic [2:0] a,
                       input logic [15:0] wd, output logic [15:0] rd, output int lat);
      @(negedge clk);
      hst_req = 1'b1; hst_we = we; hst_wide = wide; hst_addr = a; hst_wdata = wd;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!hst_ack && lat < 1000);
      rd = hst_rdata;
      hst_req = 1'b0;
   endtask

   task automatic set_mode(input logic [7:0] m);
      logic [15:0] d; int l;
      hacc(1'b1, 1'b0, 3'd4, {8'h00, m}, d, l);
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #1500000;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [15:0] d;
      int l;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 pins", {nf_ce_n, nf_we_n, nf_re_n, nf_doe, pwr_en, led_en, hst_ack},
          {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0});
      hacc(1'b0, 1'b0, 3'd4, 16'h0, d, l);
      chk("R1 mode", d, 16'h0000);

      // R2 / R3 full mode sweep
      for (int m = 0; m < 256; m++) begin
         logic [7:0] mb;
         mb = 8'(m);
         set_mode(mb);
         hacc(1'b0, 1'b0, 3'd4, 16'h0, d, l);
         chk("R2 readback", d, {8'h00, mb});
         chk("R2 pins", {nf_wp_n, nf_ce_n, led_en, nf_ale, nf_cle},
             {mb[7], ~mb[4], mb[2], mb[1], mb[0]});
         chk("R3 power", pwr_en, mb[3] & mb[2]);
         chk("R10 reg latency", l, 1);
      end

      // R3 named cases
      set_mode(8'h0C); chk("R3 power on", pwr_en, 1'b1);
      set_mode(8'h08); chk("R3 power off", pwr_en, 1'b0);
      set_mode(8'h00); chk("R3 standby", {nf_ce_n, nf_cle, nf_ale}, 3'b100);

      // R4 status
      nf_rb_n = 1'b0; repeat (4) @(negedge clk);
      hacc(1'b0, 1'b0, 3'd5, 16'h0, d, l); chk("R4 busy", d, 16'h0080);
      nf_rb_n = 1'b1; repeat (4) @(negedge clk);
      hacc(1'b0, 1'b0, 3'd5, 16'h0, d, l); chk("R4 ready", d, 16'h0000);

      // R5 narrow writes in each phase
      set_mode(8'h95); lg_n = 0;
      hacc(1'b1, 1'b0, 3'd0, 16'hA570, d, l);
      chk("R5 cmd count", lg_n, 1);
      chk("R5 cmd byte", {lg_c[0], lg_a[0], lg_b[0]}, {1'b1, 1'b0, 8'h70});
      chk("R9 we width", lg_w[0], S);
      chk("R10 narrow latency", l, 1 + (S + H));
      set_mode(8'h96); lg_n = 0;
      hacc(1'b1, 1'b0, 3'd0, 16'hFF12, d, l);
      chk("R5 addr", {lg_n[7:0], lg_c[0], lg_a[0], lg_b[0]}, {8'd1, 1'b0, 1'b1, 8'h12});
      set_mode(8'h94); lg_n = 0;
      hacc(1'b1, 1'b0, 3'd0, 16'h0034, d, l);
      chk("R5 data", {lg_n[7:0], lg_c[0], lg_a[0], lg_b[0]}, {8'd1, 1'b0, 1'b0, 8'h34});

      // R6 wide writes
      for (int k = 0; k < 16; k++) begin
         logic [15:0] w;
         w = 16'(k * 16'h1357 + 16'h0A0B);
         lg_n = 0;
         hacc(1'b1, 1'b1, 3'd0, w, d, l);
         chk("R6 count", lg_n, 2);
         chk("R6 order", {lg_b[0], lg_b[1]}, {w[7:0], w[15:8]});
         chk("R9 widths", {lg_w[0][7:0], lg_w[1][7:0]}, {8'(S), 8'(S)});
         chk("R10 wide latency", l, 1 + 2 * (S + H));
      end

      // R7 wide reads
      for (int k = 0; k < 16; k++) begin
         int base, n0;
         base = rd_idx; n0 = rd_n;
         hacc(1'b0, 1'b1, 3'd0, 16'h0, d, l);
         chk("R7 data", d, {pat(base + 1), pat(base)});
         chk("R7 count", rd_n - n0, 2);
         chk("R9 re width", rd_w, S);
      end

      // R8 narrow reads
      for (int k = 0; k < 4; k++) begin
         int base, n0;
         base = rd_idx; n0 = rd_n;
         hacc(1'b0, 1'b0, 3'd0, 16'h0, d, l);
         chk("R8 data", d, {8'h00, pat(base)});
         chk("R8 count", rd_n - n0, 1);
      end

      // R10 ack is one cycle wide
      @(negedge clk);
      chk("R10 ack pulse", hst_ack, 1'b0);

      summary();
   end

endmodule